// File: doc/BRIEF.md
# Embedded-Clock Deframer with Lock Detector

This block sits behind a clock-and-data recovery front end. It takes the recovered serial stream one bit at a time, qualified by a bit-valid strobe. Each 12-bit frame carries a leading marker bit of 1, ten payload bits, and a trailing marker bit of 0. The block searches for the frame boundary by checking that marker pair. Once a single alignment has shown clean markers for eight frames in a row, it declares lock. From then on it presents each payload word in parallel, with a one-cycle word strobe and a derived word-clock level.

The state machine has three states:
- `ST_OFF` is entered whenever power-down is low.
- `ST_HUNT` is the alignment search.
- `ST_LOCK` is the aligned state.

The transitions are:
- power-down low goes from any state to `ST_OFF`.
- power-down high goes from `ST_OFF` to `ST_HUNT`.
- eight consecutive valid frames go from `ST_HUNT` to `ST_LOCK`.
- four consecutive invalid frames go from `ST_LOCK` back to `ST_HUNT`.

In `ST_HUNT`, every invalid frame slips the candidate boundary by one bit. Return to hunting after a loss resumes at the alignment in use at that moment.

Tri-state behaviour at the pins is represented by two drive flags, one for the data group and one for the lock output. The data group is the payload, the word strobe and the word clock. Its outputs read zero whenever that group is not driven.

Top module: `emb_deframer`

## Requirements
- R1: A frame is 12 bits in arrival order: one marker bit of 1, payload bits p0 through p9, then one marker bit of 0. A frame is valid only if both marker values match. Payload bit pk appears on `data_o[k]`, so the first payload bit to arrive lands on bit 0.
- R2: After reset, `lock_n_o` is 1, `data_drv` is 0, `lock_drv` is 1, and `word_stb` is 0.
- R3: In `ST_HUNT`, lock is declared on the eighth consecutive valid frame at one alignment. `lock_n_o` goes low one clock after the last bit of that frame is accepted, and not before.
- R4: In `ST_LOCK`, accepting the last bit of a frame loads its payload into `data_o` and pulses `word_stb` high for exactly one clock. Both are visible one clock after that bit.
- R5: In `ST_LOCK`, one to three consecutive invalid frames keep lock, and any valid frame clears the run. The fourth consecutive invalid frame returns the block to `ST_HUNT`, and `lock_n_o` rises one clock after its last bit.
- R6: After a loss of lock, the search restarts at the current alignment without slipping. A stream still aligned there relocks after exactly eight valid frames.
- R7: In `ST_HUNT`, an invalid frame shifts the candidate boundary by one bit. The block therefore locks on a repeated training pattern of six 1s followed by six 0s from any starting offset.
- R8: `data_drv` is 1 only while locked, with `oe` high and `pd_n` high. `word_stb` is never 1 while `data_drv` is 0.
- R9: With `oe` low and `pd_n` high, `data_drv` is 0, but `lock_drv` stays 1 and `lock_n_o` keeps tracking the lock state.
- R10: `pd_n` low clears the alignment and moves to `ST_OFF` at the next clock, making `lock_n_o` 1. With `pd_n` and `oe` both low, `lock_drv` and `data_drv` are both 0.
- R11: `wclk_o` equals `rise_sel` in the clock after a word load. It takes the opposite level once six further bits have been accepted, so a load coincides with a rising word-clock edge when `rise_sel` is 1 and a falling edge when it is 0.
- R12: A clock with `bit_vld` low accepts no bit, leaves `data_o` unchanged, and produces no `word_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Power-down, active low |
| oe | input | 1 | Output enable for the data group |
| rise_sel | input | 1 | Word-clock phase select at word load |
| bit_in | input | 1 | Recovered serial bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this clock |
| data_o | output | DATA_W | Parallel payload word |
| wclk_o | output | 1 | Word-clock level |
| word_stb | output | 1 | One-clock pulse per loaded word |
| data_drv | output | 1 | Data group is driven (0 means high impedance) |
| lock_n_o | output | 1 | Lock indicator, low while aligned |
| lock_drv | output | 1 | Lock output is driven |

## Verification
Every result of this block is registered once behind the accepted bit that caused it. The lock change, the word load, the strobe and the word-clock phase all become visible one clock after the final bit of the deciding frame. The drive flags follow `oe` combinationally, and follow `pd_n` within the same clock.

The bench drives each bit between clock edges and samples one nanosecond after the edge that accepts it. Counts of eight valid and four invalid frames are therefore checked exactly, one frame before the threshold and at it. Word-clock phase is sampled directly after the load and again after the sixth following bit.

// File: rtl/emb_dfr_pkg.sv
package emb_dfr_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } dfr_state_e;
endpackage

// File: rtl/emb_dfr_shift.sv
module emb_dfr_shift #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2,
    parameter int POS_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              slip,
    output logic              frame_end,
    output logic              frame_ok,
    output logic [DATA_W-1:0] frame_word,
    output logic [POS_W-1:0]  pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sh_q;
    logic [FRAME_W-1:0] win;

    assign win       = {sh_q[FRAME_W-2:0], bit_in};
    assign frame_end = bit_vld && (pos == LAST);
    assign frame_ok  = win[FRAME_W-1] && !win[0];

    // oldest payload bit sits just below the leading marker
    for (genvar k = 0; k < DATA_W; k++) begin : g_unpack
        assign frame_word[k] = win[FRAME_W-2-k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            pos  <= '0;
        end else if (clr) begin
            sh_q <= '0;
            pos  <= '0;
        end else if (bit_vld) begin
            sh_q <= win;
            if (slip)
                pos <= pos;
            else if (pos == LAST)
                pos <= '0;
            else
                pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/emb_dfr_fsm.sv
module emb_dfr_fsm
    import emb_dfr_pkg::*;
#(
    parameter int LOCK_GOOD = 8,
    parameter int LOSS_BAD  = 4,
    parameter int GOOD_W    = $clog2(LOCK_GOOD + 1),
    parameter int BAD_W     = $clog2(LOSS_BAD + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       frame_end,
    input  logic       frame_ok,
    output dfr_state_e state,
    output logic       slip,
    output logic       load
);
    dfr_state_e       nxt;
    logic [GOOD_W-1:0] good_q, good_d;
    logic [BAD_W-1:0]  bad_q, bad_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HUNT;
            good_q <= '0;
            bad_q  <= '0;
        end else begin
            state  <= nxt;
            good_q <= good_d;
            bad_q  <= bad_d;
        end
    end

    always_comb begin
        nxt    = state;
        good_d = good_q;
        bad_d  = bad_q;
        slip   = 1'b0;
        load   = 1'b0;
        if (!pd_n) begin
            nxt    = ST_OFF;
            good_d = '0;
            bad_d  = '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    nxt = ST_HUNT;
                end
                ST_HUNT: begin
                    if (frame_end) begin
                        if (!frame_ok) begin
                            good_d = '0;
                            slip   = 1'b1;
                        end else if (good_q == GOOD_W'(LOCK_GOOD - 1)) begin
                            good_d = '0;
                            bad_d  = '0;
                            nxt    = ST_LOCK;
                        end else begin
                            good_d = good_q + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (frame_end) begin
                        load = 1'b1;
                        if (frame_ok) begin
                            bad_d = '0;
                        end else if (bad_q == BAD_W'(LOSS_BAD - 1)) begin
                            bad_d = '0;
                            nxt   = ST_HUNT;
                        end else begin
                            bad_d = bad_q + 1'b1;
                        end
                    end
                end
                default: nxt = ST_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/emb_dfr_out.sv
module emb_dfr_out #(
    parameter int DATA_W  = 10,
    parameter int FRAME_W = DATA_W + 2,
    parameter int POS_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] frame_word,
    input  logic [POS_W-1:0]  pos,
    input  logic              locked,
    input  logic              oe,
    input  logic              pd_n,
    input  logic              rise_sel,
    output logic [DATA_W-1:0] data_o,
    output logic              wclk_o,
    output logic              word_stb,
    output logic              data_drv,
    output logic              lock_n_o,
    output logic              lock_drv
);
    localparam logic [POS_W-1:0] HALF = POS_W'(FRAME_W / 2);

    logic [DATA_W-1:0] data_q;
    logic              stb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= load;
            if (load)
                data_q <= frame_word;
        end
    end

    always_comb begin
        data_drv = locked && oe && pd_n;
        lock_drv = pd_n || oe;
        lock_n_o = !locked;
        data_o   = data_drv ? data_q : '0;
        word_stb = data_drv && stb_q;
        wclk_o   = data_drv && ((pos < HALF) ~^ rise_sel);
    end
endmodule

// File: rtl/emb_deframer.sv
module emb_deframer
    import emb_dfr_pkg::*;
#(
    parameter int DATA_W    = 10,
    parameter int LOCK_GOOD = 8,
    parameter int LOSS_BAD  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              oe,
    input  logic              rise_sel,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic [DATA_W-1:0] data_o,
    output logic              wclk_o,
    output logic              word_stb,
    output logic              data_drv,
    output logic              lock_n_o,
    output logic              lock_drv
);
    localparam int FRAME_W = DATA_W + 2;
    localparam int POS_W   = $clog2(FRAME_W);

    logic              frame_end, frame_ok, slip, load;
    logic [DATA_W-1:0] frame_word;
    logic [POS_W-1:0]  pos;
    dfr_state_e        state;

    emb_dfr_shift #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .POS_W(POS_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(!pd_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .slip(slip), .frame_end(frame_end), .frame_ok(frame_ok),
        .frame_word(frame_word), .pos(pos)
    );

    emb_dfr_fsm #(.LOCK_GOOD(LOCK_GOOD), .LOSS_BAD(LOSS_BAD)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .frame_end(frame_end),
        .frame_ok(frame_ok), .state(state), .slip(slip), .load(load)
    );

    emb_dfr_out #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .POS_W(POS_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(load), .frame_word(frame_word), .pos(pos),
        .locked(state == ST_LOCK), .oe(oe), .pd_n(pd_n), .rise_sel(rise_sel),
        .data_o(data_o), .wclk_o(wclk_o), .word_stb(word_stb), .data_drv(data_drv),
        .lock_n_o(lock_n_o), .lock_drv(lock_drv)
    );
endmodule

// File: rtl/emb_deframer_chk.sv
module emb_deframer_chk (
    input logic clk,
    input logic rst_n,
    input logic pd_n,
    input logic oe,
    input logic bit_vld,
    input logic word_stb,
    input logic data_drv,
    input logic lock_n_o,
    input logic lock_drv
);
    // R8
    drive_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_drv |-> !lock_n_o);

    // R8
    stb_needs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> data_drv);

    // R12
    no_bit_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> !word_stb);

    // R3
    lock_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n_o) |-> $past(bit_vld));

    // R10
    pd_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> lock_n_o && !data_drv);

    // R9
    lock_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_n && !oe) |-> lock_drv && !data_drv);
endmodule

bind emb_deframer emb_deframer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .oe(oe), .bit_vld(bit_vld),
    .word_stb(word_stb), .data_drv(data_drv), .lock_n_o(lock_n_o), .lock_drv(lock_drv)
);

// File: tb/emb_deframer_tb_top.sv
`timescale 1ns/1ps
module emb_deframer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b1;
    logic       oe = 1'b1;
    logic       rise_sel = 1'b1;
    logic       bit_in = 1'b0;
    logic       bit_vld = 1'b0;
    logic [9:0] data_o;
    logic       wclk_o, word_stb, data_drv, lock_n_o, lock_drv;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    emb_deframer dut_i (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .oe(oe), .rise_sel(rise_sel),
        .bit_in(bit_in), .bit_vld(bit_vld), .data_o(data_o), .wclk_o(wclk_o),
        .word_stb(word_stb), .data_drv(data_drv), .lock_n_o(lock_n_o), .lock_drv(lock_drv)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        @(posedge clk);
        #1 bit_vld = 1'b0;
    endtask

    task automatic send_frame(input logic [9:0] w, input logic good);
        send_bit(good);
        for (int k = 0; k < 10; k++) send_bit(w[k]);
        send_bit(1'b0);
    endtask

    task automatic t_reset;
        check("R2 lock_n", lock_n_o, 1);
        check("R2 data_drv", data_drv, 0);
        check("R2 lock_drv", lock_drv, 1);
        check("R2 word_stb", word_stb, 0);
    endtask

    task automatic t_acquire;
        for (int f = 0; f < 7; f++) send_frame(10'h155, 1'b1);
        check("R3 no lock at 7", lock_n_o, 1);
        check("R8 undriven in hunt", data_drv, 0);
        send_frame(10'h155, 1'b1);
        check("R3 lock at 8", lock_n_o, 0);
        check("R8 driven when locked", data_drv, 1);
    endtask

    task automatic t_word;
        send_frame(10'h2A5, 1'b1);
        check("R4 data", data_o, 10'h2A5);
        check("R4 strobe", word_stb, 1);
        check("R11 wclk after load rise", wclk_o, 1);
        send_frame(10'h001, 1'b1);
        check("R1 first payload bit on bit0", data_o, 10'h001);
    endtask

    task automatic t_stall;
        @(negedge clk);
        @(negedge clk);
        check("R12 no strobe while idle", word_stb, 0);
        check("R12 data held", data_o, 10'h001);
    endtask

    task automatic t_wclk;
        logic [11:0] bits;
        rise_sel = 1'b0;
        bits = {1'b0, 10'h3C3, 1'b1};
        for (int k = 0; k < 12; k++) begin
            send_bit(bits[k]);
            if (k == 5) check("R11 wclk after 6 bits", wclk_o, 1);
        end
        check("R11 wclk after load fall", wclk_o, 0);
        check("R4 data 3C3", data_o, 10'h3C3);
        rise_sel = 1'b1;
    endtask

    task automatic t_oe;
        @(negedge clk);
        oe = 1'b0;
        #1;
        check("R9 data undriven", data_drv, 0);
        check("R9 lock driven", lock_drv, 1);
        check("R9 lock state kept", lock_n_o, 0);
        oe = 1'b1;
    endtask

    task automatic t_loss;
        for (int f = 0; f < 3; f++) send_frame(10'h0F0, 1'b0);
        check("R5 lock held after 3 bad", lock_n_o, 0);
        send_frame(10'h0F0, 1'b1);
        for (int f = 0; f < 3; f++) send_frame(10'h0F0, 1'b0);
        check("R5 good frame clears run", lock_n_o, 0);
        send_frame(10'h0F0, 1'b0);
        check("R5 lost after 4 bad", lock_n_o, 1);
        check("R8 undriven after loss", data_drv, 0);
    endtask

    task automatic t_relock;
        for (int f = 0; f < 7; f++) send_frame(10'h0AA, 1'b1);
        check("R6 no relock at 7", lock_n_o, 1);
        send_frame(10'h0AA, 1'b1);
        check("R6 relock at 8 same alignment", lock_n_o, 0);
    endtask

    task automatic t_pd;
        @(negedge clk);
        oe   = 1'b0;
        pd_n = 1'b0;
        @(negedge clk);
        check("R10 lock undriven", lock_drv, 0);
        check("R10 data undriven", data_drv, 0);
        oe = 1'b1;
        #1;
        check("R10 lock high in power-down", lock_n_o, 1);
        pd_n = 1'b1;
    endtask

    task automatic t_training;
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        for (int f = 0; f < 25; f++) send_frame(10'h01F, 1'b1);
        check("R7 lock on training", lock_n_o, 0);
        send_frame(10'h01F, 1'b1);
        check("R7 training word", data_o, 10'h01F);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_acquire();
        t_word();
        t_stall();
        t_wclk();
        t_oe();
        t_loss();
        t_relock();
        t_pd();
        t_training();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule